// File: doc/BRIEF.md
# Rising-Edge Set/Clear Phase Detector

This block compares the phase of a reference square wave against a feedback square wave, both taken from outside the system clock domain. Each input passes through a two-flop synchroniser and a rising-edge detector. A rising edge on the reference drives the detector output high. A rising edge on the feedback drives it low. Input levels and duty cycles play no part. Averaged over one reference period, the output's high fraction grows linearly with the phase lag of the feedback. It spans the full 0 to 360 degree range, and a 50 % high fraction marks the 180 degree centre point.

When the reference stops, an internal gap counter runs up to a limit. Once the limit is reached, the output is held high so that a downstream oscillator is driven towards its top frequency. An optional meter counts, for each reference period, the system-clock cycles in which the output was high and the length of the period. It reports both values with a one-cycle strobe, so loop behaviour can be checked without analog averaging.

Top module: `pd_seq_detector`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, `pd_out` goes low at the next clock edge and `meas_valid` stays low.
- R2: A reference rising edge that is first sampled at clock edge E0 makes `pd_out` high after edge E2. Before that edge, `pd_out` shows no change.
- R3: A feedback rising edge that is first sampled at clock edge E0 makes `pd_out` low after edge E2, unless the reference-missing condition of R8 holds.
- R4: When both inputs show a rising edge in the same system-clock cycle, the clear wins and `pd_out` goes low.
- R5: Only rising transitions matter. Two pulse trains with the same edge positions but different high times on either input give identical measurements.
- R6: `meas_valid` pulses for exactly one cycle at each reference rising edge except the first one after reset.
- R7: With reference period P cycles and feedback rising D cycles after each reference rise (0 < D < P), every measurement reports `meas_high` = D and `meas_period` = P.
- R8: After MISS_LIMIT consecutive cycles with no reference rising edge, `pd_out` is held high and feedback edges do not lower it. The next reference rising edge ends the hold.
- R9: A reset applied in mid-operation returns `pd_out` to low and disarms the meter, so the first reference edge after reset produces no measurement.
- R10: When the feedback never rises, every measurement reports `meas_high` = `meas_period`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference square wave, asynchronous |
| fb_in | input | 1 | Feedback square wave, asynchronous |
| pd_out | output | 1 | Registered detector output (high = speed up) |
| meas_valid | output | 1 | One-cycle strobe for a new measurement |
| meas_high | output | CW | Cycles the output was high during the last reference period |
| meas_period | output | CW | Length of the last reference period in cycles |

## Verification
Two situations are hard to reach from the ports. The first is a reference edge and a feedback edge landing in the same synchronised cycle. The bench produces it by driving two identical waveforms with zero lag, so both synchronisers see the rise on the same clock edge and the clear priority shows up as zero high cycles in every measurement. The second is the starved-reference hold. It needs more than a thousand quiet cycles on the reference while the feedback keeps toggling, and the bench then confirms that a single reference edge followed by a feedback edge brings the output low again.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

    // Decoded event pair seen by the set/clear core: {set, clear}
    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_CLR  = 2'b01,
        EV_SET  = 2'b10,
        EV_BOTH = 2'b11
    } pd_event_t;

    typedef struct packed {
        logic sr;    // set/clear memory bit
        logic miss;  // reference starved
        logic pd;    // registered output
    } core_flags_t;

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/pd_edge.sv
module pd_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = rst ? '0 : lvl;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_rise
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/pd_core.sv
module pd_core
    import pd_seq_pkg::*;
#(
    parameter int MISS_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_ev,
    output logic pd,
    output logic miss
);
    localparam int GW = $clog2(MISS_LIMIT + 1);
    localparam logic [GW-1:0] LIM = GW'(MISS_LIMIT);

    typedef struct packed {
        core_flags_t  f;
        logic [GW-1:0] gap;
    } core_st_t;

    core_st_t st_d, st_q;
    pd_event_t ev;

    always_comb begin
        ev   = pd_event_t'({set_ev, clr_ev});
        st_d = st_q;

        case (ev)
            EV_SET:  st_d.f.sr = 1'b1;
            EV_CLR:  st_d.f.sr = 1'b0;
            EV_BOTH: st_d.f.sr = 1'b0;   // clear has priority
            default: st_d.f.sr = st_q.f.sr;
        endcase

        if (set_ev) begin
            st_d.gap = '0;
        end else if (st_q.gap != LIM) begin
            st_d.gap = st_q.gap + 1'b1;
        end

        st_d.f.miss = (st_d.gap == LIM);
        st_d.f.pd   = st_d.f.miss | st_d.f.sr;

        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pd   = st_q.f.pd;
    assign miss = st_q.f.miss;
endmodule

// File: rtl/pd_meter.sv
module pd_meter #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_ev,
    input  logic          pd,
    output logic          valid,
    output logic [CW-1:0] high_cnt,
    output logic [CW-1:0] period_cnt
);
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic          armed;
        logic          valid;
        logic [CW-1:0] acc;
        logic [CW-1:0] per;
        logic [CW-1:0] hi_out;
        logic [CW-1:0] per_out;
    } meter_st_t;

    meter_st_t st_d, st_q;
    logic [CW-1:0] acc_next;

    always_comb begin
        acc_next = (pd && st_q.acc != CMAX) ? st_q.acc + 1'b1 : st_q.acc;

        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.acc   = acc_next;
        st_d.per   = (st_q.per != CMAX) ? st_q.per + 1'b1 : st_q.per;

        if (ref_ev) begin
            if (st_q.armed) begin
                st_d.valid   = 1'b1;
                st_d.hi_out  = acc_next;
                st_d.per_out = st_q.per;
            end
            st_d.armed = 1'b1;
            st_d.acc   = '0;
            st_d.per   = CW'(1);
        end

        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign valid      = st_q.valid;
    assign high_cnt   = st_q.hi_out;
    assign period_cnt = st_q.per_out;
endmodule

// File: rtl/pd_seq_detector.sv
module pd_seq_detector #(
    parameter int CW         = 12,
    parameter int MISS_LIMIT = 1024,
    parameter bit METER_EN   = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_in,
    input  logic          fb_in,
    output logic          pd_out,
    output logic          meas_valid,
    output logic [CW-1:0] meas_high,
    output logic [CW-1:0] meas_period
);
    localparam int NIN = 2;

    logic [NIN-1:0] raw, synced, rises;
    logic ref_ev, fb_ev, miss;

    assign raw = {fb_in, ref_in};

    pd_sync #(.W(NIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    pd_edge #(.W(NIN)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (synced),
        .rise (rises)
    );

    assign ref_ev = rises[0];
    assign fb_ev  = rises[1];

    pd_core #(.MISS_LIMIT(MISS_LIMIT)) u_core (
        .clk    (clk),
        .rst    (rst),
        .set_ev (ref_ev),
        .clr_ev (fb_ev),
        .pd     (pd_out),
        .miss   (miss)
    );

    if (METER_EN) begin : g_meter
        pd_meter #(.CW(CW)) u_meter (
            .clk        (clk),
            .rst        (rst),
            .ref_ev     (ref_ev),
            .pd         (pd_out),
            .valid      (meas_valid),
            .high_cnt   (meas_high),
            .period_cnt (meas_period)
        );
    end else begin : g_no_meter
        assign meas_valid  = 1'b0;
        assign meas_high   = '0;
        assign meas_period = '0;
    end
endmodule

// File: rtl/pd_seq_detector_chk.sv
module pd_seq_detector_chk #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          pd_out,
    input logic          meas_valid,
    input logic [CW-1:0] meas_high,
    input logic [CW-1:0] meas_period,
    input logic          ref_ev,
    input logic          fb_ev,
    input logic          miss
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!pd_out && !meas_valid));

    // R2
    set_edge_raises_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_ev && !fb_ev) |=> pd_out);

    // R3
    clear_edge_lowers_chk: assert property (@(posedge clk) disable iff (rst)
        fb_ev |=> (pd_out == miss));

    // R4
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_ev && fb_ev) |=> !pd_out);

    // R8
    starved_holds_high_chk: assert property (@(posedge clk) disable iff (rst)
        miss |-> pd_out);

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        meas_valid |=> !meas_valid);

    // R7
    high_within_period_chk: assert property (@(posedge clk) disable iff (rst)
        meas_valid |-> (meas_high <= meas_period));
endmodule

bind pd_seq_detector pd_seq_detector_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pd_out      (pd_out),
    .meas_valid  (meas_valid),
    .meas_high   (meas_high),
    .meas_period (meas_period),
    .ref_ev      (ref_ev),
    .fb_ev       (fb_ev),
    .miss        (miss)
);

// File: tb/sim_pd_seq_detector.sv
module sim_pd_seq_detector;
    localparam int CW    = 12;
    localparam int LIMIT = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic pd_out, meas_valid;
    logic [CW-1:0] meas_high, meas_period;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    hi;
        int    per;
        string req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    pd_seq_detector #(.CW(CW), .MISS_LIMIT(LIMIT)) u0 (
        .clk         (clk),
        .rst         (rst),
        .ref_in      (ref_in),
        .fb_in       (fb_in),
        .pd_out      (pd_out),
        .meas_valid  (meas_valid),
        .meas_high   (meas_high),
        .meas_period (meas_period)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ref_in = 1'b0;
        fb_in = 1'b0;
        cycles(3);
        check("R1 pd_out in reset", int'(pd_out), 0);
        check("R1 meas_valid in reset", int'(meas_valid), 0);
        rst = 1'b0;
    endtask

    // Drive a periodic pair of waves; push the expected measurements first.
    task automatic train(input int p, input int dly, input int n, input int ref_hi,
                         input int fb_hi, input int exp_hi, input string req);
        for (int k = 0; k < n - 1; k++) begin
            exp_t e;
            e.hi = exp_hi;
            e.per = p;
            e.req = req;
            sb.push_back(e);
        end
        for (int c = 0; c < n * p; c++) begin
            ref_in = ((c % p) < ref_hi);
            fb_in  = (c >= dly) && (((c - dly) % p) < fb_hi);
            @(negedge clk);
        end
        ref_in = 1'b0;
        fb_in = 1'b0;
        cycles(6);
        check({req, " scoreboard drained"}, sb.size(), 0);
        sb.delete();
    endtask

    // Monitor: compare every strobe against the scoreboard head.
    always @(negedge clk) begin
        if (!rst && meas_valid) begin
            if (sb.size() == 0) begin
                check("R6 unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " meas_high"}, int'(meas_high), e.hi);
                check({e.req, " meas_period"}, int'(meas_period), e.per);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        do_reset();
        cycles(4);
        check("R1 idle after reset", int'(pd_out), 0);

        // R2 latency of the set edge
        ref_in = 1'b1;
        cycles(2);
        check("R2 no change after E1", int'(pd_out), 0);
        cycles(1);
        check("R2 high after E2", int'(pd_out), 1);
        // R5 a held level produces no further effect
        cycles(5);
        check("R5 level hold keeps high", int'(pd_out), 1);

        // R3 latency of the clear edge
        fb_in = 1'b1;
        cycles(2);
        check("R3 no change after E1", int'(pd_out), 1);
        cycles(1);
        check("R3 low after E2", int'(pd_out), 0);
        ref_in = 1'b0;
        cycles(4);
        check("R5 falling ref ignored", int'(pd_out), 0);
        fb_in = 1'b0;

        // R8 starved reference
        do_reset();
        cycles(100);
        fb_in = 1'b1; cycles(3); fb_in = 1'b0;
        cycles(400);
        check("R8 low before limit", int'(pd_out), 0);
        cycles(LIMIT - 480);
        check("R8 forced high", int'(pd_out), 1);
        fb_in = 1'b1; cycles(4); fb_in = 1'b0; cycles(4);
        check("R8 feedback ignored while starved", int'(pd_out), 1);
        ref_in = 1'b1; cycles(4); ref_in = 1'b0; cycles(2);
        check("R8 ref edge keeps high", int'(pd_out), 1);
        fb_in = 1'b1; cycles(4); fb_in = 1'b0;
        check("R8 released by ref edge", int'(pd_out), 0);

        // Measurement trains
        do_reset();
        train(20, 5, 6, 10, 10, 5, "R7 quarter lag");
        do_reset();
        train(20, 5, 6, 2, 17, 5, "R5 other duty");
        do_reset();
        train(16, 0, 5, 8, 8, 0, "R4 same-cycle edges");
        do_reset();
        train(24, 23, 5, 12, 3, 23, "R7 near full lag");
        do_reset();
        train(30, 15, 5, 15, 15, 15, "R7 half lag");
        do_reset();
        train(12, 0, 5, 6, 0, 12, "R10 feedback absent");

        // R9 reset in mid-operation, then no strobe on first edge
        do_reset();
        ref_in = 1'b1; cycles(6);
        check("R9 high before reset", int'(pd_out), 1);
        rst = 1'b1; cycles(1);
        check("R9 reset lowers output", int'(pd_out), 0);
        rst = 1'b0; ref_in = 1'b0; cycles(4);
        ref_in = 1'b1; cycles(8);
        check("R9 no strobe after reset", sb.size(), 0);
        ref_in = 1'b0; cycles(4);

        finish_run();
    end
endmodule